// File: doc/BRIEF.md
# Dual-Half Graphic LCD Byte Writer

This block paints single bytes onto a 128×64 monochrome graphic panel whose surface is divided into a left and a right 64×64 half. Each half has its own controller chip and its own select line. Inside a half, a byte covers 8 vertically stacked pixels and is located by a 6-bit column and a 3-bit page (a band of 8 rows). A caller gives the half, column, page and byte. The block then runs the whole panel handshake. It checks the busy flag before every command, sends the column, sends the page and writes the byte, and it reports completion with a one-clock pulse.

After reset the block first holds the panel reset line low for a set time. It then blanks the panel, because the panel comes up with every pixel lit. To do this it walks every byte of both halves and writes zero. Only after that pass does it start accepting requests. The data bus to the panel is bidirectional. The block drives `lcd_db_out` only when `lcd_db_oe` is high. During status reads it releases the bus, and it reads bit 7 of the pad through `lcd_db_in_b7`. The pad buffer that combines these pins sits outside this block. The strobe timing is set in system clocks by parameters, so that each phase lasts at least 500 ns at the chosen clock.

Top module: `glcd_writer`

## Requirements
- R1: While `rst` is high, `lcd_strobe`, `done`, `init_done`, `req_ready` and `panel_reset_n` are all low. `panel_reset_n` rises on the RST_HOLD_CYC-th rising clock edge after `rst` falls. `lcd_strobe` never goes high while `panel_reset_n` is low.
- R2: After the panel reset, the block writes byte 0x00 to all 1024 locations. Half 0 comes before half 1, pages run 0 to 7 inside each half, and columns run 0 to 63 inside each page, with the column changing fastest. When this pass ends, `init_done` and `req_ready` rise in the same clock.
- R3: Each byte write is a fixed series of bus transfers: status read, column command, status read, page command, status read, data write. The column command is 0x40 OR column and the page command is 0xB8 OR page, both with `lcd_is_data` = 0. The data write carries the byte with `lcd_is_data` = 1. Nothing else is sent.
- R4: Half 0 drives `lcd_sel_left`=1 and `lcd_sel_right`=0. Half 1 drives the opposite. Exactly one select is high during every strobe, and a write never changes the other half.
- R5: A status read has `lcd_read`=1 and `lcd_is_data`=0. `lcd_db_oe` is low from at least one clock before the strobe rises until the strobe has fallen. `lcd_db_in_b7` is sampled in the last strobe-high clock. A value of 1 means busy, and the status read is then repeated. No command or data transfer is strobed while the panel is busy.
- R6: The strobe stays high for exactly E_HIGH_CYC clocks. After it falls, it stays low for at least E_LOW_CYC clocks before it rises again.
- R7: `lcd_read`, `lcd_is_data`, both selects, `lcd_db_out` and `lcd_db_oe` hold their values during the clock before the strobe rises and for the whole time the strobe is high.
- R8: A request is taken only in a clock where `req_valid` and `req_ready` are both high, and `req_ready` is low in the next clock. While `req_ready` is low (during the blanking pass or during a write), `req_valid` has no effect and causes no bus write. `req_ready` is never high without `init_done`.
- R9: After the data transfer's strobe-low phase ends, `done` is high for exactly one clock, and `req_ready` rises in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request to write one byte |
| req_half | input | 1 | Target half: 0 left, 1 right |
| req_col | input | 6 | Target column within the half |
| req_page | input | 3 | Target 8-row page |
| req_data | input | 8 | Byte to write, bit 0 at the top row |
| req_ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-clock pulse when a requested write completes |
| init_done | output | 1 | Blanking pass finished |
| panel_reset_n | output | 1 | Panel reset line, active low |
| lcd_sel_left | output | 1 | Select for the left-half controller |
| lcd_sel_right | output | 1 | Select for the right-half controller |
| lcd_read | output | 1 | 1 for a read transfer, 0 for a write |
| lcd_is_data | output | 1 | 1 for display data, 0 for command or status |
| lcd_strobe | output | 1 | Enable strobe of the panel |
| lcd_db_out | output | 8 | Data bus value to drive |
| lcd_db_oe | output | 1 | Drive enable for the data bus |
| lcd_db_in_b7 | input | 1 | Bit 7 of the data bus pad (busy flag) |

## Verification
The hardest case to produce from the ports is a status read that comes back busy, because the block has to re-poll several times before it may strobe the next command. The bench's panel model holds its busy flag for a programmable number of clocks after every write it accepts. In one phase this hold is made longer than a whole strobe cycle, so each command is preceded by a chain of busy status reads. The model counts those busy reads, and it flags any command strobed while its flag is still set. A second case that is hard to reach is a request presented while the block is busy. The bench raises `req_valid` during the blanking pass and again in the middle of a write, then confirms that no extra write reaches the model's pixel memory.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

  // Fixed by the panel's command encoding
  localparam int COL_W  = 6;
  localparam int PAGE_W = 3;
  localparam int HALF_W = 1;

  localparam logic [1:0] CMD_COL_TAG  = 2'b01;
  localparam logic [4:0] CMD_PAGE_TAG = 5'b10111;

  typedef enum logic [2:0] {
    STEP_STAT0 = 3'd0,
    STEP_COL   = 3'd1,
    STEP_STAT1 = 3'd2,
    STEP_PAGE  = 3'd3,
    STEP_STAT2 = 3'd4,
    STEP_DATA  = 3'd5
  } step_e;

  typedef enum logic [1:0] {
    B_IDLE, B_SETUP, B_HIGH, B_LOW
  } bus_ph_e;

  typedef enum logic [1:0] {
    Q_PRST, Q_ISSUE, Q_WAIT, Q_IDLE
  } seq_st_e;

  typedef struct packed {
    logic       rd;
    logic       di;
    logic [7:0] dat;
  } bus_op_t;

  function automatic logic is_status(input step_e s);
    return (s == STEP_STAT0) || (s == STEP_STAT1) || (s == STEP_STAT2);
  endfunction

  function automatic bus_op_t make_op(input step_e s,
                                      input logic [COL_W-1:0] col,
                                      input logic [PAGE_W-1:0] page,
                                      input logic [7:0] dat);
    bus_op_t o;
    o.rd  = 1'b0;
    o.di  = 1'b0;
    o.dat = 8'h00;
    case (s)
      STEP_COL:  o.dat = {CMD_COL_TAG, col};
      STEP_PAGE: o.dat = {CMD_PAGE_TAG, page};
      STEP_DATA: begin
        o.di  = 1'b1;
        o.dat = dat;
      end
      default:   o.rd = 1'b1;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/glcd_bus.sv
module glcd_bus
  import glcd_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int E_HIGH_CYC = 25,
  parameter int E_LOW_CYC  = 25,
  parameter int SEL_W      = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  bus_op_t            op,
  input  logic [SEL_W-1:0]   sel_in,
  input  logic               db7_in,
  output logic               fin,
  output logic               rd_busy,
  output logic               strobe,
  output logic               rd,
  output logic               is_data,
  output logic [SEL_W-1:0]   sel,
  output logic [7:0]         dout,
  output logic               oe
);

  localparam int MAX_A = (SETUP_CYC > E_HIGH_CYC) ? SETUP_CYC : E_HIGH_CYC;
  localparam int MAX_C = (MAX_A > E_LOW_CYC) ? MAX_A : E_LOW_CYC;
  localparam int CW    = $clog2(MAX_C + 1);

  bus_ph_e       ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= B_IDLE;
      cnt     <= '0;
      fin     <= 1'b0;
      rd_busy <= 1'b0;
      strobe  <= 1'b0;
      rd      <= 1'b0;
      is_data <= 1'b0;
      sel     <= '0;
      dout    <= 8'h00;
      oe      <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (ph)
        B_IDLE: begin
          if (start) begin
            rd      <= op.rd;
            is_data <= op.di;
            sel     <= sel_in;
            dout    <= op.dat;
            oe      <= ~op.rd;
            cnt     <= CW'(SETUP_CYC - 1);
            ph      <= B_SETUP;
          end
        end
        B_SETUP: begin
          if (cnt == '0) begin
            strobe <= 1'b1;
            cnt    <= CW'(E_HIGH_CYC - 1);
            ph     <= B_HIGH;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_HIGH: begin
          if (cnt == '0) begin
            strobe <= 1'b0;
            if (rd) rd_busy <= db7_in;
            cnt    <= CW'(E_LOW_CYC - 1);
            ph     <= B_LOW;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        B_LOW: begin
          if (cnt == '0) begin
            fin <= 1'b1;
            ph  <= B_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: ph <= B_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/glcd_walk.sv
module glcd_walk #(
  parameter int HALF_W = 1,
  parameter int PAGE_W = 3,
  parameter int COL_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              load,
  input  logic              adv,
  input  logic [HALF_W-1:0] ld_half,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic [COL_W-1:0]  ld_col,
  output logic [HALF_W-1:0] half,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col,
  output logic              last
);

  localparam int LW = HALF_W + PAGE_W + COL_W;

  // Column is the low field so it changes fastest during the walk
  logic [LW-1:0] loc;

  always_ff @(posedge clk) begin
    if (rst || clr)  loc <= '0;
    else if (load)   loc <= {ld_half, ld_page, ld_col};
    else if (adv)    loc <= loc + 1'b1;
  end

  assign {half, page, col} = loc;
  assign last = &loc;

endmodule

// File: rtl/glcd_seq.sv
module glcd_seq
  import glcd_pkg::*;
#(
  parameter int RST_HOLD_CYC = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [7:0] req_data,
  input  logic       fin,
  input  logic       rd_busy,
  input  logic       last,
  output logic       start,
  output logic       w_clr,
  output logic       w_load,
  output logic       w_adv,
  output step_e      step,
  output logic [7:0] dat,
  output logic       ready,
  output logic       done,
  output logic       init_done,
  output logic       prst_n
);

  localparam int RW = $clog2(RST_HOLD_CYC + 1);

  seq_st_e       st;
  logic [RW-1:0] rcnt;
  logic          clearing;
  logic          step_end;

  assign start    = (st == Q_ISSUE);
  assign w_clr    = (st == Q_PRST);
  assign w_load   = (st == Q_IDLE) && req_valid;
  assign step_end = (st == Q_WAIT) && fin && (step == STEP_DATA);
  assign w_adv    = step_end && clearing && !last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= Q_PRST;
      rcnt      <= '0;
      clearing  <= 1'b0;
      step      <= STEP_STAT0;
      dat       <= 8'h00;
      ready     <= 1'b0;
      done      <= 1'b0;
      init_done <= 1'b0;
      prst_n    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        Q_PRST: begin
          if (rcnt == RW'(RST_HOLD_CYC - 1)) begin
            prst_n   <= 1'b1;
            clearing <= 1'b1;
            dat      <= 8'h00;
            step     <= STEP_STAT0;
            st       <= Q_ISSUE;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        Q_ISSUE: st <= Q_WAIT;
        Q_WAIT: begin
          if (fin) begin
            if (is_status(step) && rd_busy) begin
              st <= Q_ISSUE;
            end else if (step != STEP_DATA) begin
              step <= step_e'(step + 3'd1);
              st   <= Q_ISSUE;
            end else if (clearing && !last) begin
              step <= STEP_STAT0;
              st   <= Q_ISSUE;
            end else begin
              if (clearing) init_done <= 1'b1;
              else          done      <= 1'b1;
              clearing <= 1'b0;
              ready    <= 1'b1;
              st       <= Q_IDLE;
            end
          end
        end
        Q_IDLE: begin
          if (req_valid) begin
            ready <= 1'b0;
            dat   <= req_data;
            step  <= STEP_STAT0;
            st    <= Q_ISSUE;
          end
        end
        default: st <= Q_PRST;
      endcase
    end
  end

endmodule

// File: rtl/glcd_writer.sv
module glcd_writer
  import glcd_pkg::*;
#(
  parameter int SETUP_CYC    = 1,
  parameter int E_HIGH_CYC   = 25,
  parameter int E_LOW_CYC    = 25,
  parameter int RST_HOLD_CYC = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_half,
  input  logic [COL_W-1:0]  req_col,
  input  logic [PAGE_W-1:0] req_page,
  input  logic [7:0]        req_data,
  output logic              req_ready,
  output logic              done,
  output logic              init_done,
  output logic              panel_reset_n,
  output logic              lcd_sel_left,
  output logic              lcd_sel_right,
  output logic              lcd_read,
  output logic              lcd_is_data,
  output logic              lcd_strobe,
  output logic [7:0]        lcd_db_out,
  output logic              lcd_db_oe,
  input  logic              lcd_db_in_b7
);

  localparam int NSEL = 1 << HALF_W;

  logic              start, fin, rd_busy, last;
  logic              w_clr, w_load, w_adv;
  step_e             step;
  logic [7:0]        dat;
  logic [HALF_W-1:0] half;
  logic [PAGE_W-1:0] page;
  logic [COL_W-1:0]  col;
  logic [NSEL-1:0]   sel_dec, sel_q;
  bus_op_t           op;

  glcd_seq #(.RST_HOLD_CYC(RST_HOLD_CYC)) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_data(req_data),
    .fin(fin), .rd_busy(rd_busy), .last(last),
    .start(start), .w_clr(w_clr), .w_load(w_load), .w_adv(w_adv),
    .step(step), .dat(dat),
    .ready(req_ready), .done(done), .init_done(init_done),
    .prst_n(panel_reset_n)
  );

  glcd_walk #(.HALF_W(HALF_W), .PAGE_W(PAGE_W), .COL_W(COL_W)) u_walk (
    .clk(clk), .rst(rst),
    .clr(w_clr), .load(w_load), .adv(w_adv),
    .ld_half(req_half), .ld_page(req_page), .ld_col(req_col),
    .half(half), .page(page), .col(col), .last(last)
  );

  generate
    for (genvar gi = 0; gi < NSEL; gi++) begin : g_sel
      assign sel_dec[gi] = (int'(half) == gi);
    end
  endgenerate

  assign op = make_op(step, col, page, dat);

  glcd_bus #(
    .SETUP_CYC(SETUP_CYC), .E_HIGH_CYC(E_HIGH_CYC),
    .E_LOW_CYC(E_LOW_CYC), .SEL_W(NSEL)
  ) u_bus (
    .clk(clk), .rst(rst),
    .start(start), .op(op), .sel_in(sel_dec), .db7_in(lcd_db_in_b7),
    .fin(fin), .rd_busy(rd_busy),
    .strobe(lcd_strobe), .rd(lcd_read), .is_data(lcd_is_data),
    .sel(sel_q), .dout(lcd_db_out), .oe(lcd_db_oe)
  );

  assign lcd_sel_left  = sel_q[0];
  assign lcd_sel_right = sel_q[1];

endmodule

// File: rtl/glcd_writer_chk.sv
module glcd_writer_chk #(
  parameter int E_HIGH = 25
) (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       done,
  input logic       init_done,
  input logic       panel_reset_n,
  input logic       sel_left,
  input logic       sel_right,
  input logic       rd,
  input logic       is_data,
  input logic       strobe,
  input logic [7:0] db_out,
  input logic       db_oe
);

  logic [15:0] hcnt;
  logic [12:0] bundle;

  assign bundle = {rd, is_data, sel_left, sel_right, db_out, db_oe};

  always_ff @(posedge clk) begin
    if (rst)         hcnt <= '0;
    else if (strobe) hcnt <= hcnt + 1'b1;
    else             hcnt <= '0;
  end

  AST_QUIET_IN_PANEL_RESET: assert property (@(posedge clk) disable iff (rst)
    !panel_reset_n |-> !strobe); // R1

  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (sel_left ^ sel_right)); // R4

  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (strobe && rd) |-> !db_oe); // R5

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe) |-> (hcnt == 16'(E_HIGH))); // R6

  AST_SETUP_STABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe) |-> $stable(bundle)); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    (strobe && $past(strobe)) |-> $stable(bundle)); // R7

  AST_READY_NEEDS_INIT: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> init_done); // R8

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !strobe); // R8

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9

  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready); // R9

endmodule

bind glcd_writer glcd_writer_chk #(.E_HIGH(E_HIGH_CYC)) u_chk (
  .clk(clk), .rst(rst),
  .req_ready(req_ready), .done(done), .init_done(init_done),
  .panel_reset_n(panel_reset_n),
  .sel_left(lcd_sel_left), .sel_right(lcd_sel_right),
  .rd(lcd_read), .is_data(lcd_is_data), .strobe(lcd_strobe),
  .db_out(lcd_db_out), .db_oe(lcd_db_oe)
);

// File: tb/glcd_writer_bench.sv
module glcd_writer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SETUP_CYC  = 1;
  localparam int E_HIGH_CYC = 2;
  localparam int E_LOW_CYC  = 2;
  localparam int RST_HOLD   = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_half;
  logic [5:0] req_col;
  logic [2:0] req_page;
  logic [7:0] req_data;
  logic       req_ready, done, init_done, panel_reset_n;
  logic       sel_l, sel_r, rd, is_data, strobe, db_oe, db7;
  logic [7:0] db_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  glcd_writer #(
    .SETUP_CYC(SETUP_CYC), .E_HIGH_CYC(E_HIGH_CYC),
    .E_LOW_CYC(E_LOW_CYC), .RST_HOLD_CYC(RST_HOLD)
  ) u_glcd_writer (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_half(req_half), .req_col(req_col),
    .req_page(req_page), .req_data(req_data),
    .req_ready(req_ready), .done(done), .init_done(init_done),
    .panel_reset_n(panel_reset_n),
    .lcd_sel_left(sel_l), .lcd_sel_right(sel_r),
    .lcd_read(rd), .lcd_is_data(is_data), .lcd_strobe(strobe),
    .lcd_db_out(db_out), .lcd_db_oe(db_oe), .lcd_db_in_b7(db7)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  // ---------------- panel model and scoreboard monitor ----------------
  logic [7:0]  mem [0:1][0:7][0:63];
  logic [17:0] exp_q [$];
  int  busy_len = 2;
  int  busy_cnt = 0;
  bit  last_busy = 1'b0;
  int  busy_reads = 0;
  int  n_writes = 0;
  int  seq_err = 0, sel_err = 0, viol_err = 0, drive_err = 0;
  int  width_err = 0, gap_err = 0, stab_err = 0;
  int  phase = 0;
  int  hi_cnt = 0, lo_cnt = 0;
  bit  seen_rise = 1'b0;
  logic        prev_en = 1'b0;
  logic [12:0] prev_bundle = '0;
  logic [5:0]  m_col [0:1];
  logic [2:0]  m_page [0:1];

  assign db7 = (strobe && rd) ? (busy_cnt != 0) : 1'b0;

  initial begin
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 64; c++)
          mem[h][p][c] = 8'hFF;
    for (int h = 0; h < 2; h++) begin
      m_col[h]  = '0;
      m_page[h] = '0;
    end
  end

  always @(negedge clk) begin
    logic [12:0] bnd;
    int hf;
    bnd = {rd, is_data, sel_l, sel_r, db_out, db_oe};
    if (!rst) begin
      // R7 / R6 / R5 bus timing
      if (strobe && !prev_en) begin
        if (bnd != prev_bundle) stab_err++;
        if (seen_rise && lo_cnt < E_LOW_CYC) gap_err++;
        seen_rise = 1'b1;
        hi_cnt = 1;
      end else if (strobe) begin
        if (bnd != prev_bundle) stab_err++;
        hi_cnt++;
      end
      if (strobe && rd && db_oe) drive_err++;
      if (!strobe) lo_cnt++;
      // transfer completes on strobe fall
      if (!strobe && prev_en) begin
        lo_cnt = 1;
        if (hi_cnt != E_HIGH_CYC) width_err++;
        hf = 0;
        if (sel_l && !sel_r) hf = 0;
        else if (sel_r && !sel_l) hf = 1;
        else sel_err++;
        if (rd) begin
          if (is_data) seq_err++;
          if (last_busy) busy_reads++;
          if (phase == 0 || phase == 2 || phase == 4) phase++;
        end else begin
          if (busy_cnt != 0) viol_err++;
          if (!is_data && db_out[7:6] == 2'b01) begin
            if (phase != 1) seq_err++;
            m_col[hf] = db_out[5:0];
            phase = 2;
          end else if (!is_data && db_out[7:3] == 5'b10111) begin
            if (phase != 3) seq_err++;
            m_page[hf] = db_out[2:0];
            phase = 4;
          end else if (is_data) begin
            logic [17:0] got, want;
            if (phase != 5) seq_err++;
            phase = 0;
            n_writes++;
            got = {hf[0], m_page[hf], m_col[hf], db_out};
            if (exp_q.size() == 0) begin
              check(1'b0, "R8 unexpected bus write", int'(got), -1);
            end else begin
              want = exp_q.pop_front();
              check(got == want, "R3 data write item", int'(got), int'(want));
            end
            mem[hf][m_page[hf]][m_col[hf]] = db_out;
            m_col[hf] = m_col[hf] + 6'd1;
          end else begin
            seq_err++;
          end
          busy_cnt = busy_len;
        end
      end
      if (busy_cnt > 0) busy_cnt--;
      if (strobe && rd) last_busy = (busy_cnt != 0);
    end
    prev_en = strobe;
    prev_bundle = bnd;
  end

  // ---------------- driver ----------------
  task automatic send(input bit h, input int c, input int p, input int d);
    int guard = 0;
    while (!req_ready && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    req_valid = 1'b1;
    req_half  = h;
    req_col   = 6'(c);
    req_page  = 3'(p);
    req_data  = 8'(d);
    exp_q.push_back({h, 3'(p), 6'(c), 8'(d)});
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 ready low after accept", int'(req_ready), 0);
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check(done == 1'b1, "R9 done seen", int'(done), 1);
    check(req_ready == 1'b1, "R9 ready with done", int'(req_ready), 1);
    @(negedge clk);
    check(done == 1'b0, "R9 done one clock", int'(done), 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    report();
  end

  // ---------------- main stimulus ----------------
  initial begin
    int low_cnt, guard, nz, w0, br0;
    rst = 1'b1;
    req_valid = 1'b0;
    req_half = 1'b0;
    req_col = '0;
    req_page = '0;
    req_data = '0;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 64; c++)
          exp_q.push_back({1'(h), 3'(p), 6'(c), 8'h00});
    repeat (5) @(negedge clk);
    // R1 reset state
    check({strobe, done, init_done, req_ready, panel_reset_n} == 5'b0,
          "R1 outputs low in reset",
          int'({strobe, done, init_done, req_ready, panel_reset_n}), 0);
    rst = 1'b0;
    low_cnt = 0;
    guard = 0;
    forever begin
      @(negedge clk);
      if (panel_reset_n) break;
      low_cnt++;
      guard++;
      if (guard > 1000) break;
    end
    check(low_cnt == RST_HOLD - 1, "R1 panel reset hold", low_cnt, RST_HOLD - 1);

    // R8: request during blanking pass is ignored
    repeat (200) @(negedge clk);
    req_valid = 1'b1;
    req_half = 1'b1;
    req_col = 6'd9;
    req_page = 3'd2;
    req_data = 8'h5A;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (req_ready) check(1'b0, "R8 ready during blanking", 1, 0);
    end
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 ready low in blanking", int'(req_ready), 0);

    guard = 0;
    while (!init_done && guard < 120000) begin
      @(negedge clk);
      guard++;
    end
    check(init_done == 1'b1, "R2 init_done", int'(init_done), 1);
    check(req_ready == 1'b1, "R2 ready with init_done", int'(req_ready), 1);
    check(n_writes == 1024, "R2 blanking write count", n_writes, 1024);
    check(exp_q.size() == 0, "R2 blanking queue drained", exp_q.size(), 0);
    nz = 0;
    for (int h = 0; h < 2; h++)
      for (int p = 0; p < 8; p++)
        for (int c = 0; c < 64; c++)
          if (mem[h][p][c] != 8'h00) nz++;
    check(nz == 0, "R2 panel blank", nz, 0);

    // R3/R4 user writes
    send(1'b0, 0, 0, 8'hA5);  wait_done();
    send(1'b1, 63, 7, 8'h3C); wait_done();
    send(1'b0, 17, 3, 8'hFF); wait_done();
    send(1'b1, 40, 5, 8'h81); wait_done();
    check(mem[0][0][0] == 8'hA5, "R3 left 0/0", int'(mem[0][0][0]), 'hA5);
    check(mem[1][7][63] == 8'h3C, "R4 right corner", int'(mem[1][7][63]), 'h3C);
    check(mem[0][7][63] == 8'h00, "R4 left untouched", int'(mem[0][7][63]), 0);
    check(mem[0][3][17] == 8'hFF, "R3 left 3/17", int'(mem[0][3][17]), 'hFF);
    check(mem[1][5][40] == 8'h81, "R4 right 5/40", int'(mem[1][5][40]), 'h81);
    check(mem[1][3][17] == 8'h00, "R4 right untouched", int'(mem[1][3][17]), 0);

    // R8: request while a write is in progress is ignored
    send(1'b0, 10, 1, 8'h11);
    req_valid = 1'b1;
    req_half = 1'b1;
    req_col = 6'd30;
    req_page = 3'd4;
    req_data = 8'hEE;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    w0 = n_writes;
    repeat (60) @(negedge clk);
    check(n_writes == w0, "R8 no extra write", n_writes, w0);
    check(mem[0][1][10] == 8'h11, "R8 accepted byte", int'(mem[0][1][10]), 'h11);
    check(mem[1][4][30] == 8'h00, "R8 ignored byte", int'(mem[1][4][30]), 0);

    // R5: long busy forces repeated status reads
    busy_len = 30;
    br0 = busy_reads;
    send(1'b1, 5, 6, 8'h66);
    wait_done();
    check(busy_reads - br0 >= 3, "R5 busy re-poll", busy_reads - br0, 3);
    check(mem[1][6][5] == 8'h66, "R5 byte after busy", int'(mem[1][6][5]), 'h66);

    check(seq_err == 0, "R3 transfer order", seq_err, 0);
    check(sel_err == 0, "R4 single select", sel_err, 0);
    check(viol_err == 0, "R5 no command while busy", viol_err, 0);
    check(drive_err == 0, "R5 bus released on read", drive_err, 0);
    check(width_err == 0, "R6 strobe high width", width_err, 0);
    check(gap_err == 0, "R6 strobe low gap", gap_err, 0);
    check(stab_err == 0, "R7 setup and hold", stab_err, 0);
    report();
  end

endmodule